// File: doc/BRIEF.md
# Parallel Frame Sync Code Detector

This block looks for one of three constant 11-bit sync patterns in the overhead bits of a minor frame. A word-delay store gathers bit 0 of overhead words 1 to 11 and presents them in parallel. The block takes that sample together with the current word index. A comparison only counts in the word slot that completes the sample.

When a pattern matches, the block latches which code it was and emits an active-low sync strobe one clock wide. It also sets a parallel sync latch for that code. The parallel sync latch stays set until serial sync maintenance reports an error. After such an error the block reacquires in a later minor frame. While frame lock is reported as established, no new match is accepted.

Top module: `frame_sync_detect`

## Requirements
- R1: After the synchronous active-high reset, `sync_n` is 1 and both `code_en` and `par_sync_en` are 0.
- R2: Suppose the sample equals one of the three codes while `word_idx` equals `SYNC_WORD` (default 11) and `lock_est` is 0. Then `sync_n` is 0 for exactly one clock. The low period starts after the second rising edge that follows that compare cycle.
- R3: On that same edge, `code_en` becomes one-hot. Bit 0 marks `CODE_A`, bit 1 marks `CODE_B` and bit 2 marks `CODE_C`. `par_sync_en` goes to 1 with it.
- R4: A matching sample presented in any word slot other than `SYNC_WORD` gives no strobe and sets no latch.
- R5: A sample that differs from all three codes in any bit gives no strobe and sets no latch.
- R6: While `lock_est` is 1, no match is accepted. The block gives no strobe and sets no latch.
- R7: Once a parallel sync latch is set, a later match of any code still gives a strobe. It leaves `code_en` unchanged.
- R8: When `err_clr` is 1 at a rising edge, `code_en` and `par_sync_en` clear at that edge. A later qualified match acquires again.
- R9: A match held in the sync slot for several clocks gives only one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovh_bits | input | 11 | Parallel overhead sample; bit 0 comes from word 1 |
| word_idx | input | IDX_W | Index of the current word in the minor frame |
| lock_est | input | 1 | Frame lock established; inhibits matching |
| err_clr | input | 1 | Error reset from serial sync maintenance |
| code_en | output | 3 | Acquired code, one-hot (A, B, C) |
| par_sync_en | output | 1 | Parallel sync acquired |
| sync_n | output | 1 | Active-low frame sync strobe, one clock wide |

## Verification
The hardest situations to reach from the ports involve a latch that is already set. The first is a new match arriving after a parallel sync latch is already held. The second is a match that stays in the sync slot for several clocks. Both would hide a wrong strobe or a wrong latch update if the latches were always cleared between trials. The stimulus therefore leaves the block acquired on purpose and then presents a different code. It also holds a matching sample at the sync slot for four clocks. In both cases it counts strobe clocks and watches `code_en` across the window.

// File: rtl/frame_sync_detect.sv
module frame_sync_detect #(
  parameter int          IDX_W     = 5,
  parameter int          SYNC_WORD = 11,
  parameter logic [10:0] CODE_A    = 11'h712,
  parameter logic [10:0] CODE_B    = 11'h1A5,
  parameter logic [10:0] CODE_C    = 11'h64B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [10:0]      ovh_bits,
  input  logic [IDX_W-1:0] word_idx,
  input  logic             lock_est,
  input  logic             err_clr,
  output logic [2:0]       code_en,
  output logic             par_sync_en,
  output logic             sync_n
);
  localparam int NCODE = 3;
  localparam logic [IDX_W-1:0] SLOT = IDX_W'(SYNC_WORD);
  localparam logic [10:0] CODES [NCODE] = '{CODE_A, CODE_B, CODE_C};

  logic [NCODE-1:0] hit, sel, cmp_lat, par_lat;
  logic at_slot, cmp_any, prev_any, first;

  assign at_slot = (word_idx == SLOT);

  for (genvar i = 0; i < NCODE; i++) begin : g_cmp
    assign hit[i] = (ovh_bits == CODES[i]);
  end

  always_comb begin
    sel = '0;
    for (int i = NCODE - 1; i >= 0; i--)
      if (hit[i]) sel = NCODE'(1) << i;
  end

  assign cmp_any = |cmp_lat;
  assign first   = cmp_any & ~prev_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lat  <= '0;
      par_lat  <= '0;
      prev_any <= 1'b0;
      sync_n   <= 1'b1;
    end else begin
      prev_any <= cmp_any;
      sync_n   <= ~first;
      if (lock_est || !at_slot)
        cmp_lat <= '0;
      else if (!cmp_any)
        cmp_lat <= sel;
      if (err_clr)
        par_lat <= '0;
      else if (first && par_lat == '0)
        par_lat <= cmp_lat;
    end
  end

  assign code_en     = par_lat;
  assign par_sync_en = |par_lat;

  p_pulse_one_r2: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> sync_n);
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(code_en));
  p_acq_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(par_sync_en) |-> !sync_n);
  p_lock_r6: assert property (@(posedge clk) disable iff (rst)
    lock_est && $past(lock_est) |=> sync_n);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    par_sync_en && !err_clr |=> $stable(code_en));
  p_err_clr_r8: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> !par_sync_en);
endmodule

// File: tb/frame_sync_detect_tb.sv
module frame_sync_detect_tb_top;
  localparam int CLK_P = 10;
  localparam logic [10:0] CA = 11'h712, CB = 11'h1A5, CC = 11'h64B;
  localparam int NV = 9;
  // {exp_en[3], exp_pulse, lock, word[5], pattern[11]}
  localparam logic [20:0] VEC [NV] = '{
    {3'b001, 1'b1, 1'b0, 5'd11, CA},
    {3'b010, 1'b1, 1'b0, 5'd11, CB},
    {3'b100, 1'b1, 1'b0, 5'd11, CC},
    {3'b000, 1'b0, 1'b0, 5'd10, CA},
    {3'b000, 1'b0, 1'b0, 5'd12, CC},
    {3'b000, 1'b0, 1'b0, 5'd11, CA ^ 11'h001},
    {3'b000, 1'b0, 1'b0, 5'd11, CC ^ 11'h400},
    {3'b000, 1'b0, 1'b1, 5'd11, CB},
    {3'b000, 1'b0, 1'b0, 5'd11, 11'h000}
  };

  logic clk = 0, rst = 1, lock_est = 0, err_clr = 0;
  logic [10:0] ovh_bits = '0;
  logic [4:0] word_idx = '0;
  logic [2:0] code_en;
  logic par_sync_en, sync_n;
  int nchk = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_sync_detect dut_i (.clk, .rst, .ovh_bits, .word_idx, .lock_est,
    .err_clr, .code_en, .par_sync_en, .sync_n);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    ovh_bits = '0; word_idx = '0; lock_est = 0; err_clr = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lows;
    @(negedge clk); tick(); tick();
    rst = 0;
    chk("R1 sync_n", 8'(sync_n), 8'd1);
    chk("R1 code_en", 8'(code_en), 8'd0);
    chk("R1 par_sync_en", 8'(par_sync_en), 8'd0);

    // table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      ovh_bits = VEC[v][10:0]; word_idx = VEC[v][15:11]; lock_est = VEC[v][16];
      tick();
      idle();
      chk("R2/R4/R5/R6 no early strobe", 8'(sync_n), 8'd1);
      tick();
      chk("R2/R4/R5/R6 strobe", 8'(sync_n), 8'(!VEC[v][17]));
      chk("R3/R4/R5/R6 code_en", 8'(code_en), 8'(VEC[v][20:18]));
      chk("R3 par_sync_en", 8'(par_sync_en), 8'(|VEC[v][20:18]));
      tick();
      chk("R2 strobe width", 8'(sync_n), 8'd1);
      err_clr = 1; tick(); err_clr = 0;
      chk("R8 clear", 8'(code_en), 8'd0);
    end

    // R9: match held four clocks in the slot
    ovh_bits = CB; word_idx = 5'd11; lows = 0;
    for (int k = 0; k < 4; k++) begin tick(); if (!sync_n) lows++; end
    idle();
    for (int k = 0; k < 3; k++) begin tick(); if (!sync_n) lows++; end
    chk("R9 one strobe", 8'(lows), 8'd1);
    chk("R9 code_en", 8'(code_en), 8'b010);

    // R7: still acquired as B, present C
    ovh_bits = CC; word_idx = 5'd11; tick(); idle(); tick();
    chk("R7 strobe", 8'(sync_n), 8'd0);
    chk("R7 code_en held", 8'(code_en), 8'b010);
    tick();

    // R8: error clear then reacquire with A
    err_clr = 1; tick(); err_clr = 0;
    chk("R8 par_sync_en cleared", 8'(par_sync_en), 8'd0);
    ovh_bits = CA; word_idx = 5'd11; tick(); idle(); tick();
    chk("R8 reacquire", 8'(code_en), 8'b001);
    tick();
    err_clr = 1; tick(); err_clr = 0;

    // R6: lock held over a long matching slot
    lock_est = 1; tick();
    ovh_bits = CC; word_idx = 5'd11; lows = 0;
    for (int k = 0; k < 4; k++) begin tick(); if (!sync_n) lows++; end
    idle();
    tick(); if (!sync_n) lows++;
    chk("R6 no strobe under lock", 8'(lows), 8'd0);
    chk("R6 code_en", 8'(code_en), 8'd0);

    // R1: reset mid-acquisition
    ovh_bits = CB; word_idx = 5'd11; tick(); idle(); tick();
    rst = 1; tick(); rst = 0;
    chk("R1 reset clears code_en", 8'(code_en), 8'd0);
    chk("R1 reset sync_n", 8'(sync_n), 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule